// File: doc/BRIEF.md
# Sample Record Filter

This block sits between the stage that finishes collecting a profiling sample and the stage that writes samples to memory. One finished record may arrive per cycle. Each record holds an operation kind (load, store, branch or other), a 12-bit event vector and a total latency. The latency counts from the cycle the operation was picked for sampling, so it includes queueing as well as execution. The block checks the record against three programmable tests and either forwards it or drops it.

The first test selects operation kinds. The second requires a set of event bits, and only the filterable event positions take part. The third sets a latency floor. A kept record goes into an output register and is offered downstream with valid/ready. A dropped record stops in this block: it raises a one-cycle pulse and goes no further. Two counters give the number of kept and dropped records. While a kept record is waiting for downstream ready, the upstream side is stalled.

Top module: `sample_record_filter`

## Requirements
- R1: After reset, `out_valid` and `drop_pulse` are 0, both counters are 0 and `in_ready` is 1.
- R2: Kind encoding: 0 = load, 1 = store, 2 = branch, 3 = other. If any of `cfg_load_only`, `cfg_store_only` or `cfg_branch_only` is set, a record passes the kind test only if its kind matches one of the enabled kinds. If none of them is set, every kind passes.
- R3: Every filterable bit set in `cfg_event_mask` must also be set in `in_events`. A mask of 0 turns the event test off. The filterable positions are bit 1 (retired), bit 3 (L1 data refill), bit 5 (TLB refill), bit 7 (mispredict) and bit 11 (misaligned). So mask 0x002 keeps only retired operations and mask 0x080 keeps only mispredicted ones.
- R4: Mask bits at any position other than 1, 3, 5, 7 and 11 have no effect on the decision.
- R5: A record passes the latency test only if `in_latency >= cfg_min_latency`.
- R6: A record accepted at a clock edge (`in_valid && in_ready`) that passes all three tests appears on `out_valid`/`out_*` after that edge, with its fields unchanged. It stays stable until an edge where `out_ready` is 1.
- R7: An accepted record that fails any test never reaches the output. It makes `drop_pulse` high for exactly the one cycle after its acceptance edge.
- R8: `in_ready` equals `!out_valid || out_ready`. Upstream therefore stalls while a kept record waits.
- R9: `kept_count` and `drop_count` rise by one on each kept or dropped acceptance and wrap at their width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load_only | input | 1 | Enable load kind |
| cfg_store_only | input | 1 | Enable store kind |
| cfg_branch_only | input | 1 | Enable branch kind |
| cfg_event_mask | input | 12 | Required event bits |
| cfg_min_latency | input | 16 | Latency floor |
| in_valid | input | 1 | Record present |
| in_ready | output | 1 | Record can be taken |
| in_kind | input | 2 | Operation kind |
| in_events | input | 12 | Event vector |
| in_latency | input | 16 | Latency since selection |
| out_valid | output | 1 | Kept record present |
| out_ready | input | 1 | Downstream takes record |
| out_kind | output | 2 | Kept record kind |
| out_events | output | 12 | Kept record events |
| out_latency | output | 16 | Kept record latency |
| drop_pulse | output | 1 | One-cycle drop indication |
| kept_count | output | 16 | Kept records |
| drop_count | output | 16 | Dropped records |

## Verification
Every result is due one edge after the acceptance edge that causes it: the kept record on `out_*`, the drop pulse and the counter steps. `in_ready` is the only combinational result and follows `out_ready` within the same cycle. The bench drives inputs on the falling edge. A behavioural queue model updates on each rising edge and is compared 2 ns after the next falling edge, after `out_ready` has settled. Directed sends check the output on the first falling edge after acceptance, and the stall sequence checks that the held data stays the same across several blocked cycles.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'd0,
    OP_STORE  = 2'd1,
    OP_BRANCH = 2'd2,
    OP_OTHER  = 2'd3
  } op_kind_e;

  // positions whose mask bit takes part in the event test
  function automatic logic is_filterable(input int pos);
    return (pos == 1) || (pos == 3) || (pos == 5) || (pos == 7) || (pos == 11);
  endfunction
endpackage

// File: rtl/srf_kind_match.sv
module srf_kind_match (
  input  logic [1:0] kind,
  input  logic       en_load,
  input  logic       en_store,
  input  logic       en_branch,
  output logic       pass
);
  import srf_pkg::*;

  logic any_en;
  logic hit;

  always_comb begin
    any_en = en_load | en_store | en_branch;
    hit    = (en_load   && (kind == OP_LOAD))  ||
             (en_store  && (kind == OP_STORE)) ||
             (en_branch && (kind == OP_BRANCH));
    pass   = !any_en || hit;
  end
endmodule

// File: rtl/srf_event_match.sv
module srf_event_match #(
  parameter int EVT_W = 12
) (
  input  logic [EVT_W-1:0] events,
  input  logic [EVT_W-1:0] mask,
  output logic             pass
);
  logic [EVT_W-1:0] bit_ok;

  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    localparam logic FILT = srf_pkg::is_filterable(i);
    if (FILT) begin : g_used
      assign bit_ok[i] = !mask[i] || events[i];
    end else begin : g_ignored
      assign bit_ok[i] = 1'b1;
    end
  end

  assign pass = &bit_ok;
endmodule

// File: rtl/srf_counter.sv
module srf_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/sample_record_filter.sv
module sample_record_filter #(
  parameter int EVT_W = 12,
  parameter int LAT_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load_only,
  input  logic             cfg_store_only,
  input  logic             cfg_branch_only,
  input  logic [EVT_W-1:0] cfg_event_mask,
  input  logic [LAT_W-1:0] cfg_min_latency,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_kind,
  input  logic [EVT_W-1:0] in_events,
  input  logic [LAT_W-1:0] in_latency,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [1:0]       out_kind,
  output logic [EVT_W-1:0] out_events,
  output logic [LAT_W-1:0] out_latency,
  output logic             drop_pulse,
  output logic [CNT_W-1:0] kept_count,
  output logic [CNT_W-1:0] drop_count
);
  localparam int REC_W = 2 + EVT_W + LAT_W;

  logic             kind_ok;
  logic             evt_ok;
  logic             lat_ok;
  logic             keep;
  logic             accept;
  logic             load_out;
  logic             drop_now;

  logic             vld_d, vld_q;
  logic             drp_d, drp_q;
  logic [REC_W-1:0] rec_d, rec_q;

  srf_kind_match u_kind (
    .kind      (in_kind),
    .en_load   (cfg_load_only),
    .en_store  (cfg_store_only),
    .en_branch (cfg_branch_only),
    .pass      (kind_ok)
  );

  srf_event_match #(.EVT_W(EVT_W)) u_evt (
    .events (in_events),
    .mask   (cfg_event_mask),
    .pass   (evt_ok)
  );

  // decision and handshake
  always_comb begin
    lat_ok   = (in_latency >= cfg_min_latency);
    keep     = kind_ok && evt_ok && lat_ok;
    in_ready = !vld_q || out_ready;
    accept   = in_valid && in_ready;
    load_out = accept && keep;
    drop_now = accept && !keep;
  end

  // next state of output stage
  always_comb begin
    vld_d = load_out || (vld_q && !out_ready);
    drp_d = drop_now;
    rec_d = rec_q;
    if (load_out) rec_d = {in_kind, in_events, in_latency};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      drp_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      drp_q <= drp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rec_q <= '0;
    else        rec_q <= rec_d;
  end

  srf_counter #(.CNT_W(CNT_W)) u_kept_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (load_out),
    .count (kept_count)
  );

  srf_counter #(.CNT_W(CNT_W)) u_drop_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (drop_now),
    .count (drop_count)
  );

  assign out_valid   = vld_q;
  assign drop_pulse  = drp_q;
  assign out_kind    = rec_q[REC_W-1 -: 2];
  assign out_events  = rec_q[LAT_W +: EVT_W];
  assign out_latency = rec_q[LAT_W-1:0];
endmodule

// File: rtl/sample_record_filter_chk.sv
module sample_record_filter_chk #(
  parameter int EVT_W = 12,
  parameter int LAT_W = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_kind,
  input logic [EVT_W-1:0] out_events,
  input logic [LAT_W-1:0] out_latency,
  input logic             drop_pulse,
  input logic [CNT_W-1:0] kept_count,
  input logic [CNT_W-1:0] drop_count
);
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready); // R8
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R8
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_events) && $stable(out_latency))); // R6
  AST_NEW_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready)); // R6
  AST_DROP_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(in_valid && in_ready)); // R7
  AST_KEPT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (kept_count - $past(kept_count)) <= CNT_W'(1)); // R9
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count - $past(drop_count)) <= CNT_W'(1)); // R9
endmodule

bind sample_record_filter sample_record_filter_chk #(
  .EVT_W(EVT_W), .LAT_W(LAT_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
  .out_events(out_events), .out_latency(out_latency), .drop_pulse(drop_pulse),
  .kept_count(kept_count), .drop_count(drop_count)
);

// File: tb/sample_record_filter_test.sv
`timescale 1ns/1ps
module sample_record_filter_test;
  logic        clk;
  logic        rst_n;
  logic        cfg_load_only, cfg_store_only, cfg_branch_only;
  logic [11:0] cfg_event_mask;
  logic [15:0] cfg_min_latency;
  logic        in_valid, in_ready;
  logic [1:0]  in_kind;
  logic [11:0] in_events;
  logic [15:0] in_latency;
  logic        out_valid, out_ready;
  logic [1:0]  out_kind;
  logic [11:0] out_events;
  logic [15:0] out_latency;
  logic        drop_pulse;
  logic [15:0] kept_count, drop_count;

  int total = 0;
  int bad = 0;

  sample_record_filter uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_load_only(cfg_load_only), .cfg_store_only(cfg_store_only),
    .cfg_branch_only(cfg_branch_only), .cfg_event_mask(cfg_event_mask),
    .cfg_min_latency(cfg_min_latency),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_events(in_events), .in_latency(in_latency),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_events(out_events), .out_latency(out_latency),
    .drop_pulse(drop_pulse), .kept_count(kept_count), .drop_count(drop_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  function automatic logic ref_keep(input logic [1:0] k, input logic [11:0] ev, input logic [15:0] lat);
    logic any_en, kind_ok, ev_ok;
    logic [11:0] need;
    any_en  = cfg_load_only | cfg_store_only | cfg_branch_only;
    kind_ok = !any_en || (cfg_load_only && k == 2'd0) ||
              (cfg_store_only && k == 2'd1) || (cfg_branch_only && k == 2'd2);
    need    = cfg_event_mask & 12'h8AA;
    ev_ok   = ((ev & need) == need);
    return kind_ok && ev_ok && (lat >= cfg_min_latency);
  endfunction

  logic [29:0] mq[$];
  logic        m_drop;
  int          m_kept, m_dropc;
  logic        started;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_drop = 0; m_kept = 0; m_dropc = 0; started = 0;
    end else begin
      logic acc;
      started = 1;
      acc = in_valid && (mq.size() == 0 || out_ready);
      if (mq.size() > 0 && out_ready) void'(mq.pop_front());
      m_drop = 0;
      if (acc) begin
        if (ref_keep(in_kind, in_events, in_latency)) begin
          mq.push_back({in_kind, in_events, in_latency});
          m_kept++;
        end else begin
          m_drop = 1;
          m_dropc++;
        end
      end
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && started) begin
      logic ev_v;
      ev_v = (mq.size() > 0);
      chk(out_valid == ev_v, "R6 out_valid", out_valid, ev_v);
      if (ev_v) chk({out_kind, out_events, out_latency} == mq[0], "R6 record", {out_kind, out_events, out_latency}, mq[0]);
      chk(drop_pulse == m_drop, "R7 drop_pulse", drop_pulse, m_drop);
      chk(in_ready == (!ev_v || out_ready), "R8 in_ready", in_ready, (!ev_v || out_ready));
      chk(kept_count == 16'(m_kept), "R9 kept_count", kept_count, 16'(m_kept));
      chk(drop_count == 16'(m_dropc), "R9 drop_count", drop_count, 16'(m_dropc));
    end
  end

  task automatic send(input logic [1:0] k, input logic [11:0] ev, input logic [15:0] lat,
                      input logic exp_keep, input string tag);
    @(negedge clk);
    out_ready = 1; in_valid = 1; in_kind = k; in_events = ev; in_latency = lat;
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == exp_keep, tag, out_valid, exp_keep);
    chk(drop_pulse == !exp_keep, tag, drop_pulse, !exp_keep);
    if (exp_keep) chk(out_latency == lat && out_events == ev && out_kind == k, {tag, " R6 fields"}, out_latency, lat);
  endtask

  task automatic set_cfg(input logic lo, input logic so, input logic bo, input logic [11:0] m, input logic [15:0] ml);
    @(negedge clk);
    cfg_load_only = lo; cfg_store_only = so; cfg_branch_only = bo;
    cfg_event_mask = m; cfg_min_latency = ml;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; in_valid = 0; out_ready = 1; in_kind = 0; in_events = 0; in_latency = 0;
    cfg_load_only = 0; cfg_store_only = 0; cfg_branch_only = 0;
    cfg_event_mask = 0; cfg_min_latency = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && drop_pulse == 0, "R1 outputs idle", {out_valid, drop_pulse}, 0);
    chk(kept_count == 0 && drop_count == 0, "R1 counters zero", {kept_count, drop_count}, 0);
    chk(in_ready == 1, "R1 in_ready", in_ready, 1);
    rst_n = 1;

    // R2 kind selection
    send(2'd3, 12'h000, 16'd0, 1, "R2 no enables other kept");
    set_cfg(1, 0, 0, 12'h000, 16'd0);
    send(2'd0, 12'h000, 16'd1, 1, "R2 load-only load");
    send(2'd1, 12'h000, 16'd1, 0, "R2 load-only store");
    set_cfg(0, 1, 1, 12'h000, 16'd0);
    send(2'd2, 12'h000, 16'd2, 1, "R2 branch");
    send(2'd1, 12'h000, 16'd2, 1, "R2 store");
    send(2'd0, 12'h000, 16'd2, 0, "R2 load excluded");
    send(2'd3, 12'h000, 16'd2, 0, "R2 other excluded");
    // R3 event mask
    set_cfg(0, 0, 0, 12'h002, 16'd0);
    send(2'd0, 12'h00A, 16'd3, 1, "R3 retired kept");
    send(2'd0, 12'h008, 16'd3, 0, "R3 not retired");
    set_cfg(0, 0, 0, 12'h080, 16'd0);
    send(2'd2, 12'h080, 16'd3, 1, "R3 mispredict kept");
    send(2'd2, 12'h002, 16'd3, 0, "R3 no mispredict");
    set_cfg(0, 0, 0, 12'h820, 16'd0);
    send(2'd0, 12'h020, 16'd3, 0, "R3 partial mask");
    send(2'd0, 12'h820, 16'd3, 1, "R3 all mask bits");
    // R4 non-filterable mask bits
    set_cfg(0, 0, 0, 12'h001, 16'd0);
    send(2'd0, 12'h000, 16'd4, 1, "R4 bit0 ignored");
    set_cfg(0, 0, 0, 12'h754, 16'd0);
    send(2'd1, 12'h000, 16'd4, 1, "R4 high bits ignored");
    // R5 latency floor
    set_cfg(0, 0, 0, 12'h000, 16'd10);
    send(2'd0, 12'h000, 16'd9, 0, "R5 below floor");
    send(2'd0, 12'h000, 16'd10, 1, "R5 equal floor");
    send(2'd0, 12'h000, 16'hFFFF, 1, "R5 max latency");
    set_cfg(0, 0, 0, 12'h000, 16'd0);

    // R8 stall and R6 hold
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_kind = 2'd1; in_events = 12'h0; in_latency = 16'd5;
    @(negedge clk);
    in_latency = 16'd7;
    #2 chk(in_ready == 0, "R8 stalled", in_ready, 0);
    repeat (2) begin
      @(negedge clk);
      chk(out_latency == 16'd5, "R6 held under stall", out_latency, 5);
    end
    out_ready = 1;
    @(negedge clk);
    chk(out_latency == 16'd7, "R6 next after release", out_latency, 7);
    in_valid = 0;
    @(negedge clk);
    chk(out_valid == 0, "R6 drained", out_valid, 0);

    // mixed traffic against the reference model
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (n % 25 == 0) begin
        int sel;
        sel = $urandom_range(0, 3);
        cfg_load_only = 1'($urandom); cfg_store_only = 1'($urandom); cfg_branch_only = 1'($urandom);
        cfg_event_mask = (sel == 0) ? 12'h000 : (sel == 1) ? 12'h002 : (sel == 2) ? 12'h080 : 12'($urandom);
        cfg_min_latency = 16'($urandom_range(0, 40));
      end
      in_valid   = 1'($urandom);
      out_ready  = ($urandom_range(0, 3) != 0);
      in_kind    = 2'($urandom);
      in_events  = 12'($urandom);
      in_latency = 16'($urandom_range(0, 63));
    end
    @(negedge clk);
    in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule